// File: doc/BRIEF.md
# External Memory Bus Controller

This controller turns single-word requests from a processor-side port into timed cycles on an external asynchronous memory bus. It drives an address bus, a shared bidirectional data bus, one active-low select line per address space (program, data, I/O), a memory strobe and a read/write line. From these it derives active-low chip-select, write-enable and output-enable toward an SRAM-style device.

Every external access has a setup phase followed by a strobe phase. While the device holds its ready input low, the strobe phase is extended. If ready stays low for a configurable number of strobe cycles, the access is abandoned and reported as an error. Chip-select can be decoded from the space and a page in the upper address bits. Alternatively, in decode-free mode, chip-select is asserted for every access, so the device appears at every address alias and in every space.

Top module: `extbus_ctrl`

## Requirements
- R1: Space code 0 asserts only `ps_n`, code 1 asserts only `ds_n`, and codes 2 and 3 assert only `is_n`. Each is low through both phases of the access and holds steady with the address. All three are high when idle.
- R2: `rw` is high for a read and low for a write. `mstrb_n` is low through both phases of a program- or data-space access and stays high for I/O space.
- R3: An accepted request occupies one setup cycle, then at least one strobe cycle. `req_ready` is high only when the controller is idle. `rsp_valid` is high for exactly one cycle, immediately after the cycle that ends the access.
- R4: While `bus_rdy` is low at the end of a strobe cycle, the strobe phase is repeated. The access ends at the first strobe cycle that samples `bus_rdy` high.
- R5: If `bus_rdy` is low on MAX_WAIT consecutive strobe cycles, the access ends after the last of them and the response carries `rsp_err` high. A response that completes normally has `rsp_err` low.
- R6: `mem_we_n` is low only in strobe cycles of a write. `mem_oe_n` is low through both phases of a read. The controller drives `bus_data` with the write data only during a write, and releases the bus at all other times.
- R7: With `nodecode` low, `mem_cs_n` is low during an access only if the space is program or data and address bits [AW-1:LAW] equal MEM_PAGE. Writes that fail this test leave the memory unchanged.
- R8: With `nodecode` high, `mem_cs_n` is low during every access whatever its space and upper address bits, so all such addresses alias onto one device word.
- R9: For a read that completes normally, `rsp_rdata` alongside the `rsp_valid` pulse holds the `bus_data` value sampled at the clock edge that ended the access.
- R10: After reset the controller is idle, with all selects, strobe, chip-select, write-enable and output-enable high, `req_ready` high and `rsp_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| nodecode | input | 1 | Decode-free mode: chip-select on every access |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request accepted this cycle |
| req_space | input | 2 | 0 program, 1 data, 2/3 I/O |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Access ended by wait timeout |
| rsp_rdata | output | DW | Read data |
| bus_addr | output | AW | External address bus |
| bus_data | inout | DW | External data bus |
| ps_n | output | 1 | Program-space select, active low |
| ds_n | output | 1 | Data-space select, active low |
| is_n | output | 1 | I/O-space select, active low |
| mstrb_n | output | 1 | Memory strobe, active low |
| rw | output | 1 | High read, low write |
| bus_rdy | input | 1 | Device ready; low stretches the access |
| mem_cs_n | output | 1 | Memory chip-select, active low |
| mem_we_n | output | 1 | Memory write-enable, active low |
| mem_oe_n | output | 1 | Memory output-enable, active low |

## Verification
Accesses are run with zero wait states, with several waits short of the limit, and with ready held low past the limit. These separate the two-cycle base timing, the stretch logic and the timeout path. Writes to a page outside MEM_PAGE and to I/O space are each followed by a read of the same low address. In decoded mode, this shows that a write outside the decode leaves memory untouched. In decode-free mode, the same pattern shows that a write through any space or page lands in the shared word. Program, data and I/O codes are each checked against the select and strobe lines they must drive.

// File: rtl/extbus_pkg.sv
package extbus_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2
  } phase_e;

  // returns {io_n, data_n, prog_n}; codes 2 and 3 both map to I/O
  function automatic logic [2:0] space_selects_n(input logic [1:0] sp);
    logic [2:0] s;
    s = 3'b111;
    case (sp)
      2'd0:    s[0] = 1'b0;
      2'd1:    s[1] = 1'b0;
      default: s[2] = 1'b0;
    endcase
    return s;
  endfunction

  function automatic logic is_memory_space(input logic [1:0] sp);
    return (sp == 2'd0) || (sp == 2'd1);
  endfunction

endpackage

// File: rtl/extbus_waitcnt.sv
module extbus_waitcnt #(
  parameter int MAX_WAIT = 8,
  localparam int WCW = (MAX_WAIT > 1) ? $clog2(MAX_WAIT) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           inc,
  output logic [WCW-1:0] cnt,
  output logic           expire
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end

  assign expire = (cnt == WCW'(MAX_WAIT - 1));

endmodule

// File: rtl/extbus_decode.sv
module extbus_decode #(
  parameter int HW = 4,
  parameter int MEM_PAGE = 0
) (
  input  logic          active,
  input  logic          nodecode,
  input  logic [1:0]    space,
  input  logic [HW-1:0] addr_hi,
  output logic          ps_n,
  output logic          ds_n,
  output logic          is_n,
  output logic          mstrb_n,
  output logic          cs_n
);
  import extbus_pkg::*;

  logic [2:0] sel_n;
  logic       mem_sp;
  logic       page_hit;

  always_comb begin
    sel_n    = active ? space_selects_n(space) : 3'b111;
    mem_sp   = is_memory_space(space);
    page_hit = (addr_hi == HW'(MEM_PAGE));
  end

  assign ps_n    = sel_n[0];
  assign ds_n    = sel_n[1];
  assign is_n    = sel_n[2];
  assign mstrb_n = !(active && mem_sp);
  assign cs_n    = !(active && (nodecode || (mem_sp && page_hit)));

endmodule

// File: rtl/extbus_seq.sv
module extbus_seq (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                rdy,
  input  logic                expire,
  output extbus_pkg::phase_e  phase,
  output logic                req_ready,
  output logic                load,
  output logic                finish_ok,
  output logic                finish_err,
  output logic                wait_inc,
  output logic                wait_clr
);
  import extbus_pkg::*;

  phase_e nxt;

  always_comb begin
    nxt        = phase;
    load       = 1'b0;
    finish_ok  = 1'b0;
    finish_err = 1'b0;
    wait_inc   = 1'b0;
    req_ready  = (phase == PH_IDLE);
    wait_clr   = (phase != PH_STROBE);
    case (phase)
      PH_IDLE: if (req_valid) begin
        load = 1'b1;
        nxt  = PH_SETUP;
      end
      PH_SETUP: nxt = PH_STROBE;
      PH_STROBE: begin
        if (rdy) begin
          finish_ok = 1'b1;
          nxt       = PH_IDLE;
        end else if (expire) begin
          finish_err = 1'b1;
          nxt        = PH_IDLE;
        end else begin
          wait_inc = 1'b1;
        end
      end
      default: nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= nxt;
  end

endmodule

// File: rtl/extbus_ctrl.sv
module extbus_ctrl #(
  parameter int AW       = 16,
  parameter int DW       = 16,
  parameter int LAW      = 12,
  parameter int MEM_PAGE = 0,
  parameter int MAX_WAIT = 8,
  localparam int HW  = AW - LAW,
  localparam int WCW = (MAX_WAIT > 1) ? $clog2(MAX_WAIT) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          nodecode,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_space,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic          rsp_err,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] bus_addr,
  inout  wire  [DW-1:0] bus_data,
  output logic          ps_n,
  output logic          ds_n,
  output logic          is_n,
  output logic          mstrb_n,
  output logic          rw,
  input  logic          bus_rdy,
  output logic          mem_cs_n,
  output logic          mem_we_n,
  output logic          mem_oe_n
);
  import extbus_pkg::*;

  phase_e         phase;
  logic           load, finish_ok, finish_err, wait_inc, wait_clr, expire;
  logic [WCW-1:0] wait_cnt;
  logic [1:0]     space_q;
  logic           write_q;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  wdata_q;

  // named internal events for the checker
  logic active;
  logic in_strobe;
  logic drive_en;

  extbus_seq u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .rdy(bus_rdy),
    .expire(expire), .phase(phase), .req_ready(req_ready), .load(load),
    .finish_ok(finish_ok), .finish_err(finish_err),
    .wait_inc(wait_inc), .wait_clr(wait_clr)
  );

  extbus_waitcnt #(.MAX_WAIT(MAX_WAIT)) u_wait (
    .clk(clk), .rst_n(rst_n), .clr(wait_clr), .inc(wait_inc),
    .cnt(wait_cnt), .expire(expire)
  );

  assign active    = (phase != PH_IDLE);
  assign in_strobe = (phase == PH_STROBE);
  assign drive_en  = active && write_q;

  extbus_decode #(.HW(HW), .MEM_PAGE(MEM_PAGE)) u_dec (
    .active(active), .nodecode(nodecode), .space(space_q),
    .addr_hi(addr_q[AW-1:LAW]), .ps_n(ps_n), .ds_n(ds_n), .is_n(is_n),
    .mstrb_n(mstrb_n), .cs_n(mem_cs_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      space_q <= '0;
      write_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (load) begin
      space_q <= req_space;
      write_q <= req_write;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= finish_ok || finish_err;
      rsp_err   <= finish_err;
      if (finish_ok && !write_q) rsp_rdata <= bus_data;
    end
  end

  assign bus_addr = addr_q;
  assign rw       = !(active && write_q);
  assign mem_we_n = !(in_strobe && write_q);
  assign mem_oe_n = !(active && !write_q);
  assign bus_data = drive_en ? wdata_q : {DW{1'bz}};

endmodule

// File: rtl/extbus_ctrl_chk.sv
module extbus_ctrl_chk #(
  parameter int AW       = 16,
  parameter int MAX_WAIT = 8,
  parameter int WCW      = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ps_n,
  input logic          ds_n,
  input logic          is_n,
  input logic          mstrb_n,
  input logic          rw,
  input logic          mem_we_n,
  input logic          mem_oe_n,
  input logic [AW-1:0] bus_addr,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          rsp_err,
  input logic          in_strobe,
  input logic          drive_en,
  input logic [WCW-1:0] wait_cnt
);

  // R1
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~{ps_n, ds_n, is_n}));

  // R1
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_strobe |-> ($stable({ps_n, ds_n, is_n}) && $stable(bus_addr)));

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ps_n && ds_n && is_n && mstrb_n && mem_we_n));

  // R3
  pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R5
  err_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_valid);

  // R5
  wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(wait_cnt) < MAX_WAIT);

  // R6
  we_after_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!rw && $past(!rw)));

  // R6
  drive_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drive_en |-> (!rw && mem_oe_n));

endmodule

bind extbus_ctrl extbus_ctrl_chk #(.AW(AW), .MAX_WAIT(MAX_WAIT), .WCW(WCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ps_n(ps_n), .ds_n(ds_n), .is_n(is_n),
  .mstrb_n(mstrb_n), .rw(rw), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
  .bus_addr(bus_addr), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_err(rsp_err), .in_strobe(in_strobe), .drive_en(drive_en),
  .wait_cnt(wait_cnt)
);

// File: tb/extbus_ctrl_bench.sv
module extbus_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16, DW = 16, LAW = 12, MW = 4;

  logic clk = 1'b0, rst_n = 1'b0, nodecode = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, bus_rdy = 1'b0;
  logic [1:0] req_space = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_err, ps_n, ds_n, is_n, mstrb_n, rw;
  logic mem_cs_n, mem_we_n, mem_oe_n;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] bus_addr;
  wire  [DW-1:0] bus_data;

  int checks = 0, errors = 0;
  logic [DW+1:0] expq[$];          // {is_write, err, data}
  logic [DW-1:0] mem [0:(1<<LAW)-1];

  always #(CLK_PERIOD/2) clk = ~clk;

  extbus_ctrl #(.AW(AW), .DW(DW), .LAW(LAW), .MEM_PAGE(0), .MAX_WAIT(MW)) u_extbus_ctrl (
    .clk(clk), .rst_n(rst_n), .nodecode(nodecode), .req_valid(req_valid),
    .req_ready(req_ready), .req_space(req_space), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .bus_addr(bus_addr),
    .bus_data(bus_data), .ps_n(ps_n), .ds_n(ds_n), .is_n(is_n),
    .mstrb_n(mstrb_n), .rw(rw), .bus_rdy(bus_rdy), .mem_cs_n(mem_cs_n),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n)
  );

  // asynchronous SRAM model: low LAW address bits only
  assign bus_data = (!mem_cs_n && !mem_oe_n) ? mem[bus_addr[LAW-1:0]] : {DW{1'bz}};
  always @(posedge clk) if (!mem_cs_n && !mem_we_n) mem[bus_addr[LAW-1:0]] <= bus_data;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // monitor: pops expected responses on each completion pulse (R3 R5 R9)
  always @(negedge clk) if (rst_n && rsp_valid) begin
    if (expq.size() == 0) begin
      checks++; errors++;
      $display("FAIL R3 actual=unexpected_response expected=none at %0t", $time);
    end else begin
      logic [DW+1:0] e;
      e = expq.pop_front();
      chk("R5 err flag", 32'(rsp_err), 32'(e[DW]));
      if (!e[DW+1] && !e[DW]) chk("R9 read data", 32'(rsp_rdata), 32'(e[DW-1:0]));
      chk("R3 idle at response", 32'(req_ready), 32'd1);
      chk("R1 selects released", 32'({ps_n, ds_n, is_n, mstrb_n}), 32'hF);
    end
  end

  task automatic access(input logic [1:0] sp, input logic wr, input logic [AW-1:0] a,
                        input logic [DW-1:0] wd, input int waits, input logic [DW-1:0] rd_exp);
    logic [2:0] sel_exp;
    logic memsp, hit;
    int n;
    logic err;
    sel_exp = (sp == 2'd0) ? 3'b110 : (sp == 2'd1) ? 3'b101 : 3'b011;  // {is,ds,ps}
    memsp = (sp == 2'd0) || (sp == 2'd1);
    hit = nodecode || (memsp && a[AW-1:LAW] == '0);
    err = (waits >= MW);
    n = err ? MW : waits + 1;
    expq.push_back({wr, err, rd_exp});
    @(negedge clk);
    chk("R3 ready when idle", 32'(req_ready), 32'd1);
    req_space = sp; req_write = wr; req_addr = a; req_wdata = wd; req_valid = 1'b1;
    bus_rdy = 1'b0;
    @(negedge clk);                      // setup phase
    req_valid = 1'b0;
    chk("R3 busy in setup", 32'(req_ready), 32'd0);
    chk("R1 selects setup", 32'({is_n, ds_n, ps_n}), 32'(sel_exp));
    chk("R2 rw", 32'(rw), 32'(!wr));
    chk("R2 strobe", 32'(mstrb_n), 32'(!memsp));
    chk(nodecode ? "R8 chip select" : "R7 chip select", 32'(mem_cs_n), 32'(!hit));
    chk("R6 we idle in setup", 32'(mem_we_n), 32'd1);
    chk("R6 oe", 32'(mem_oe_n), 32'(wr));
    for (int k = 0; k < n; k++) begin
      @(negedge clk);                    // strobe cycle k
      chk("R4 still busy", 32'(rsp_valid), 32'd0);
      chk("R1 selects held", 32'({is_n, ds_n, ps_n}), 32'(sel_exp));
      chk("R6 we in strobe", 32'(mem_we_n), 32'(!wr));
      if (wr) chk("R6 write data driven", 32'(bus_data), 32'(wd));
      bus_rdy = (k >= waits);
    end
    @(negedge clk);                      // response cycle, checked by monitor
    chk("R3 pulse present", 32'(rsp_valid), 32'd1);
    bus_rdy = 1'b0;
    @(negedge clk);
    chk("R3 pulse one cycle", 32'(rsp_valid), 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < (1 << LAW); i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 selects", 32'({ps_n, ds_n, is_n, mstrb_n}), 32'hF);
    chk("R10 mem ctl", 32'({mem_cs_n, mem_we_n, mem_oe_n}), 32'h7);
    chk("R10 ready", 32'(req_ready), 32'd1);
    chk("R10 no response", 32'(rsp_valid), 32'd0);
    rst_n = 1'b1;

    // decoded mode
    access(2'd1, 1'b1, 16'h0010, 16'hA5A1, 0, '0);   // data write, no wait
    access(2'd1, 1'b0, 16'h0010, '0, 0, 16'hA5A1);   // R9 read back
    access(2'd0, 1'b1, 16'h0020, 16'h1234, 2, '0);   // R4 program write, 2 waits
    access(2'd0, 1'b0, 16'h0020, '0, 3, 16'h1234);   // R4 max legal stretch
    access(2'd1, 1'b1, 16'h1010, 16'hBEEF, 0, '0);   // R7 outside page
    access(2'd2, 1'b1, 16'h0010, 16'hCAFE, 1, '0);   // R7 I/O space write
    access(2'd3, 1'b1, 16'h0010, 16'hCAFE, 0, '0);   // R1 code 3 is I/O
    access(2'd1, 1'b0, 16'h0010, '0, 0, 16'hA5A1);   // R7 memory untouched
    access(2'd1, 1'b0, 16'h0020, '0, MW, '0);        // R5 timeout
    access(2'd1, 1'b0, 16'h0020, '0, 0, 16'h1234);   // recovers after timeout

    // decode-free mode
    nodecode = 1'b1;
    access(2'd2, 1'b1, 16'h5010, 16'h7777, 0, '0);   // R8 I/O write lands
    access(2'd0, 1'b0, 16'hF010, '0, 1, 16'h7777);   // R8 alias via program
    access(2'd1, 1'b1, 16'h3020, 16'h0F0F, 0, '0);   // R8 other page
    access(2'd1, 1'b0, 16'h0020, '0, 0, 16'h0F0F);   // R8 alias via page 0

    repeat (3) @(negedge clk);
    chk("R3 queue drained", 32'(expq.size()), 32'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule